// File: doc/BRIEF.md
# Dual-Reader Error Status Capture with Alert

This block records error events raised by neighbouring limit comparators, fan tach monitors and general-purpose inputs. Every event is recorded twice, in two banks of status registers that hold the same contents. Each bank belongs to one controller, for example a management controller and a host. Each controller clears bits in its own bank by writing ones, and those writes never touch the other bank. As a result, neither controller can lose an event before it has seen it.

Masks decide which events count. A general mask always applies. One extra mask is added for the sleep state that the host reports. An asserted thermal-trip input, when enabled, blocks all recording. The active-low open-drain alert has two modes. In interrupt mode it reflects latched, unmasked status. In comparator mode it follows the live temperature-class events only.

The event vector is split into registers of `REG_W` bits. Event index `r*REG_W + b` is bit `b` of status register `r`. With the defaults, 8 registers of 8 bits give 64 events. The lowest `TEMP_CNT` event indexes (default 4, indexes 0 to 3) are the temperature-class events.

Top module: `err_status_dual`

## Requirements
- R1: After reset both status banks read all zeros and `alert_no` is high.
- R2: An enabled event that is high at a rising clock edge sets its bit in both banks at that edge. The bit then stays set after the event goes low, until it is cleared.
- R3: A bank-A clear strobe with address `r` and data `d` clears exactly the bits of register `r` in bank A where `d` is 1. Other registers, bits whose data is 0, and bank B are unchanged.
- R4: A bank-B clear behaves the same way on bank B alone and leaves bank A unchanged.
- R5: A clear wins over an event in the same cycle. The bit reads 0 after the clear edge and is set again at the next edge if the event is still high.
- R6: An event whose general-mask bit is 1 is not recorded in either bank. It also drives no alert in either mode.
- R7: `sleep_i` codes are 0 for S0, 1 for S1, 3 for S3 and 4 for S4/5. Codes 1, 3 and 4 OR the matching sleep mask into the general mask. Code 0 and every other code use the general mask only.
- R8: While `trip_en_i` and `trip_i` are both 1, no event is recorded and the comparator-mode alert stays high. When `trip_en_i` is 0, `trip_i` has no effect.
- R9: In interrupt mode (`cmp_mode_i`=0), `alert_no` goes low one edge after any bit is set in either bank whose current mask bit is 0. It returns high one edge after no such bit remains, whether the bit was cleared in both banks or has since been masked.
- R10: In comparator mode (`cmp_mode_i`=1), `alert_no` is low exactly when, at the previous edge, an enabled temperature-class event was live. Latched status bits and non-temperature events have no effect on the alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | NUM_REGS*REG_W | Live error events from comparators, tach monitors, GPIs |
| gen_mask_i | input | NUM_REGS*REG_W | General mask, 1 = ignore event |
| s1_mask_i | input | NUM_REGS*REG_W | Extra mask applied in S1 |
| s3_mask_i | input | NUM_REGS*REG_W | Extra mask applied in S3 |
| s45_mask_i | input | NUM_REGS*REG_W | Extra mask applied in S4/5 |
| sleep_i | input | 3 | Current sleep state code written by the host |
| trip_i | input | 1 | Thermal-trip input, active high |
| trip_en_i | input | 1 | Lets the thermal-trip input suppress recording |
| cmp_mode_i | input | 1 | 0 = interrupt mode, 1 = comparator mode |
| clr_a_i | input | 1 | Bank A clear strobe |
| clr_a_addr_i | input | AW | Bank A register index to clear |
| clr_a_data_i | input | REG_W | Bank A bits to clear (ones clear) |
| clr_b_i | input | 1 | Bank B clear strobe |
| clr_b_addr_i | input | AW | Bank B register index to clear |
| clr_b_data_i | input | REG_W | Bank B bits to clear (ones clear) |
| stat_a_o | output | NUM_REGS*REG_W | Bank A status bits |
| stat_b_o | output | NUM_REGS*REG_W | Bank B status bits |
| alert_no | output | 1 | Alert, active low (open-drain drive level) |

## Verification
The assertions assume the following about the inputs: mask, sleep and mode inputs are synchronous to `clk_i`, and a clear strobe carries a valid register index in the same cycle. Under those assumptions, bank contents only change through a recorded event or a clear, and the alert tracks the enabled status or the live temperature events. The stimulus changes every input just after a rising edge, so each value is held across a whole cycle. It keeps clear addresses below `NUM_REGS`, and it lowers events before the banks are swept clean between scenarios, so each scenario starts from empty banks.

// File: rtl/esr_pkg.sv
package esr_pkg;
  typedef enum logic [2:0] {
    SLP_S0  = 3'd0,
    SLP_S1  = 3'd1,
    SLP_S3  = 3'd3,
    SLP_S45 = 3'd4
  } sleep_e;

  function automatic int addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/esr_mask_sel.sv
module esr_mask_sel
  import esr_pkg::*;
#(
  parameter int EV_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_W-1:0] gen_mask_i,
  input  logic [EV_W-1:0] s1_mask_i,
  input  logic [EV_W-1:0] s3_mask_i,
  input  logic [EV_W-1:0] s45_mask_i,
  input  logic [2:0]      sleep_i,
  input  logic            trip_i,
  input  logic            trip_en_i,
  output logic [EV_W-1:0] en_o,
  output logic            sup_o
);
  logic [EV_W-1:0] slp_mask;

  always_comb begin
    case (sleep_i)
      SLP_S1:  slp_mask = s1_mask_i;
      SLP_S3:  slp_mask = s3_mask_i;
      SLP_S45: slp_mask = s45_mask_i;
      default: slp_mask = '0;
    endcase
  end

  assign en_o  = ~(gen_mask_i | slp_mask);
  assign sup_o = trip_en_i & trip_i;

  // R6
  gen_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o & gen_mask_i) == '0);

  // R7
  s0_only_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i == 3'd0) |-> (en_o == ~gen_mask_i));
endmodule

// File: rtl/esr_bank.sv
module esr_bank
  import esr_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_REGS*REG_W-1:0]     set_i,
  input  logic                          clr_i,
  input  logic [addr_bits(NUM_REGS)-1:0] clr_addr_i,
  input  logic [REG_W-1:0]              clr_data_i,
  output logic [NUM_REGS*REG_W-1:0]     stat_o
);
  localparam int EV_W = NUM_REGS * REG_W;
  localparam int AW   = addr_bits(NUM_REGS);

  logic [EV_W-1:0] clr_vec;
  logic [EV_W-1:0] stat_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
    assign clr_vec[r*REG_W +: REG_W] =
      (clr_i && clr_addr_i == AW'(r)) ? clr_data_i : '0;
  end

  // clear has priority; a persisting event re-sets on the following edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q | set_i) & ~clr_vec;
  end

  assign stat_o = stat_q;

  // R5
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(clr_vec)) == '0));

  // R6
  no_spont_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(set_i)) == '0));

  // R2
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(stat_q) & ~$past(clr_vec) & ~stat_q) == '0));
endmodule

// File: rtl/esr_alert.sv
module esr_alert #(
  parameter int EV_W     = 64,
  parameter int TEMP_CNT = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_W-1:0] stat_a_i,
  input  logic [EV_W-1:0] stat_b_i,
  input  logic [EV_W-1:0] event_i,
  input  logic [EV_W-1:0] en_i,
  input  logic            sup_i,
  input  logic            cmp_mode_i,
  output logic            alert_no
);
  logic [EV_W-1:0] temp_sel;
  logic            int_hit, cmp_hit, alert_q;

  for (genvar i = 0; i < EV_W; i++) begin : g_temp
    assign temp_sel[i] = (i < TEMP_CNT);
  end

  assign int_hit = |((stat_a_i | stat_b_i) & en_i);
  assign cmp_hit = !sup_i && (|(event_i & temp_sel & en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_q <= 1'b0;
    else         alert_q <= cmp_mode_i ? cmp_hit : int_hit;
  end

  assign alert_no = ~alert_q;

  // R9
  int_alert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_mode_i && ((stat_a_i & en_i) != '0)) |=> !alert_no);

  // R10
  cmp_ignores_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_mode_i && ((event_i & temp_sel) == '0)) |=> alert_no);

  // R8
  trip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_mode_i && sup_i) |=> alert_no);
endmodule

// File: rtl/err_status_dual.sv
module err_status_dual
  import esr_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8,
  parameter int TEMP_CNT = 4,
  localparam int EV_W    = NUM_REGS * REG_W,
  localparam int AW      = addr_bits(NUM_REGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_W-1:0] event_i,
  input  logic [EV_W-1:0] gen_mask_i,
  input  logic [EV_W-1:0] s1_mask_i,
  input  logic [EV_W-1:0] s3_mask_i,
  input  logic [EV_W-1:0] s45_mask_i,
  input  logic [2:0]      sleep_i,
  input  logic            trip_i,
  input  logic            trip_en_i,
  input  logic            cmp_mode_i,
  input  logic            clr_a_i,
  input  logic [AW-1:0]   clr_a_addr_i,
  input  logic [REG_W-1:0] clr_a_data_i,
  input  logic            clr_b_i,
  input  logic [AW-1:0]   clr_b_addr_i,
  input  logic [REG_W-1:0] clr_b_data_i,
  output logic [EV_W-1:0] stat_a_o,
  output logic [EV_W-1:0] stat_b_o,
  output logic            alert_no
);
  localparam int NBANK = 2;

  logic [EV_W-1:0]  en, rec;
  logic             sup;
  logic             clr   [NBANK];
  logic [AW-1:0]    caddr [NBANK];
  logic [REG_W-1:0] cdata [NBANK];
  logic [EV_W-1:0]  stat  [NBANK];

  esr_mask_sel #(.EV_W(EV_W)) u_mask (
    .clk_i, .rst_ni,
    .gen_mask_i, .s1_mask_i, .s3_mask_i, .s45_mask_i,
    .sleep_i, .trip_i, .trip_en_i,
    .en_o (en),
    .sup_o(sup)
  );

  assign rec = sup ? '0 : (event_i & en);

  assign clr[0]   = clr_a_i;
  assign caddr[0] = clr_a_addr_i;
  assign cdata[0] = clr_a_data_i;
  assign clr[1]   = clr_b_i;
  assign caddr[1] = clr_b_addr_i;
  assign cdata[1] = clr_b_data_i;

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    esr_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
      .clk_i, .rst_ni,
      .set_i     (rec),
      .clr_i     (clr[k]),
      .clr_addr_i(caddr[k]),
      .clr_data_i(cdata[k]),
      .stat_o    (stat[k])
    );
  end

  assign stat_a_o = stat[0];
  assign stat_b_o = stat[1];

  esr_alert #(.EV_W(EV_W), .TEMP_CNT(TEMP_CNT)) u_alert (
    .clk_i, .rst_ni,
    .stat_a_i  (stat[0]),
    .stat_b_i  (stat[1]),
    .event_i,
    .en_i      (en),
    .sup_i     (sup),
    .cmp_mode_i,
    .alert_no
  );

  // R3
  a_clear_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_a_i && !clr_b_i) |=> (($past(stat_b_o) & ~stat_b_o) == '0));

  // R4
  b_clear_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_b_i && !clr_a_i) |=> (($past(stat_a_o) & ~stat_a_o) == '0));
endmodule

// File: tb/tb_err_status_dual.sv
module tb_err_status_dual;
  localparam int EV_W = 64;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [EV_W-1:0] ev = '0, gm = '0, m1 = '0, m3 = '0, m45 = '0;
  logic [2:0] slp = '0;
  logic trip = 0, trip_en = 0, cmp = 0;
  logic ca = 0, cb = 0;
  logic [2:0] caddr = '0, cbaddr = '0;
  logic [7:0] cdat = '0, cbdat = '0;
  logic [EV_W-1:0] sa, sb;
  logic alert_n;

  err_status_dual dut (
    .clk_i(clk), .rst_ni(rst_n),
    .event_i(ev), .gen_mask_i(gm), .s1_mask_i(m1), .s3_mask_i(m3), .s45_mask_i(m45),
    .sleep_i(slp), .trip_i(trip), .trip_en_i(trip_en), .cmp_mode_i(cmp),
    .clr_a_i(ca), .clr_a_addr_i(caddr), .clr_a_data_i(cdat),
    .clr_b_i(cb), .clr_b_addr_i(cbaddr), .clr_b_data_i(cbdat),
    .stat_a_o(sa), .stat_b_o(sb), .alert_no(alert_n)
  );

  typedef struct {
    string           tag;
    logic [EV_W-1:0] a;
    logic [EV_W-1:0] b;
    logic            al;
    bit              chk_al;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [EV_W-1:0] bt(input int i);
    return {{(EV_W-1){1'b0}}, 1'b1} << i;
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic expect_st(input string tag, input logic [EV_W-1:0] a,
                           input logic [EV_W-1:0] b, input logic al, input bit chk_al);
    exp_t e;
    e.tag = tag; e.a = a; e.b = b; e.al = al; e.chk_al = chk_al;
    q.push_back(e);
  endtask

  task automatic clear_all();
    ca = 0; cb = 0;
    for (int r = 0; r < 8; r++) begin
      ca = 1; cb = 1; caddr = r[2:0]; cbaddr = r[2:0]; cdat = 8'hFF; cbdat = 8'hFF;
      cyc();
    end
    ca = 0; cb = 0; cdat = '0; cbdat = '0;
    cyc();
    expect_st("sweep", '0, '0, 1'b1, 1);
  endtask

  // monitor: compares queued expectations away from the rising edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      if (sa !== cur.a || sb !== cur.b || (cur.chk_al && alert_n !== cur.al)) begin
        errors++;
        $display("FAIL %s: a=%h b=%h alert_n=%b expected a=%h b=%h alert_n=%b",
                 cur.tag, sa, sb, alert_n, cur.a, cur.b, cur.al);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    expect_st("R1 reset state", '0, '0, 1'b1, 1);

    // R2 / R9: pulse latches, alert one edge later
    ev = bt(10); cyc();
    expect_st("R2 latch on edge", bt(10), bt(10), 1'b1, 1);
    ev = '0; cyc();
    expect_st("R2 sticky, R9 alert low", bt(10), bt(10), 1'b0, 1);

    // R3 / R4 independent clears
    ca = 1; caddr = 3'd1; cdat = 8'h04; cyc();
    expect_st("R3 clear A only", '0, bt(10), 1'b0, 1);
    ca = 0; cb = 1; cbaddr = 3'd1; cbdat = 8'h04; cyc();
    expect_st("R4 clear B only", '0, '0, 1'b0, 1);
    cb = 0; cyc();
    expect_st("R9 alert released", '0, '0, 1'b1, 1);

    // R3 wrong register / wrong bit
    ev = bt(10); cyc();
    ev = '0; ca = 1; caddr = 3'd2; cdat = 8'h04; cyc();
    expect_st("R3 other register untouched", bt(10), bt(10), 1'b0, 1);
    caddr = 3'd1; cdat = 8'hFB; cyc();
    expect_st("R3 zero data bit untouched", bt(10), bt(10), 1'b0, 1);
    ca = 0;
    clear_all();

    // R5 clear against a live event
    ev = bt(20); cyc();
    expect_st("R5 set", bt(20), bt(20), 1'b1, 1);
    ca = 1; caddr = 3'd2; cdat = 8'h10; cyc();
    expect_st("R5 clear wins", '0, bt(20), 1'b0, 1);
    ca = 0; cyc();
    expect_st("R5 re-set next edge", bt(20), bt(20), 1'b0, 1);
    ev = '0;
    clear_all();

    // R6 general mask
    gm = bt(30); ev = bt(30); cyc(); cyc();
    expect_st("R6 masked not recorded", '0, '0, 1'b1, 1);
    ev = '0; gm = '0;

    // R7 sleep masks
    m1 = bt(40); m3 = bt(41); m45 = bt(42);
    slp = 3'd1; ev = bt(40) | bt(41) | bt(42); cyc();
    expect_st("R7 S1 mask", bt(41) | bt(42), bt(41) | bt(42), 1'b0, 0);
    ev = '0; clear_all();
    slp = 3'd3; ev = bt(40) | bt(41) | bt(42); cyc();
    expect_st("R7 S3 mask", bt(40) | bt(42), bt(40) | bt(42), 1'b0, 0);
    ev = '0; clear_all();
    slp = 3'd4; ev = bt(40) | bt(41) | bt(42); cyc();
    expect_st("R7 S4/5 mask", bt(40) | bt(41), bt(40) | bt(41), 1'b0, 0);
    ev = '0; clear_all();
    slp = 3'd0; ev = bt(40) | bt(41) | bt(42); cyc();
    expect_st("R7 S0 general only", bt(40) | bt(41) | bt(42), bt(40) | bt(41) | bt(42), 1'b0, 0);
    ev = '0; clear_all();
    slp = 3'd2; ev = bt(40) | bt(41) | bt(42); cyc();
    expect_st("R7 unused code", bt(40) | bt(41) | bt(42), bt(40) | bt(41) | bt(42), 1'b0, 0);
    ev = '0; clear_all();
    slp = 3'd0; m1 = '0; m3 = '0; m45 = '0;

    // R9 masking a latched bit releases the alert
    ev = bt(50); cyc();
    ev = '0; cyc();
    expect_st("R9 alert on latched", bt(50), bt(50), 1'b0, 1);
    gm = bt(50); cyc();
    expect_st("R9 masked latched bit", bt(50), bt(50), 1'b1, 1);
    gm = '0; cyc();
    expect_st("R9 unmasked again", bt(50), bt(50), 1'b0, 1);
    clear_all();

    // R8 thermal trip
    trip_en = 1; trip = 1; ev = bt(3); cyc();
    expect_st("R8 trip suppresses", '0, '0, 1'b1, 1);
    trip_en = 0; cyc();
    expect_st("R8 trip disabled no effect", bt(3), bt(3), 1'b1, 1);
    ev = '0; trip = 0;
    clear_all();

    // R10 comparator mode
    cmp = 1; ev = bt(1); cyc();
    expect_st("R10 live temp event", bt(1), bt(1), 1'b0, 1);
    ev = '0; cyc();
    expect_st("R10 ignores latched status", bt(1), bt(1), 1'b1, 1);
    clear_all();
    ev = bt(12); cyc(); cyc();
    expect_st("R10 non-temp event", bt(12), bt(12), 1'b1, 1);
    ev = '0; clear_all();
    gm = bt(1); ev = bt(1); cyc();
    expect_st("R6 masked in comparator", '0, '0, 1'b1, 1);
    gm = '0; trip_en = 1; trip = 1; cyc();
    expect_st("R8 trip quiets comparator", '0, '0, 1'b1, 1);
    trip_en = 0; trip = 0; cyc();
    expect_st("R10 comparator active", bt(1), bt(1), 1'b0, 1);
    ev = '0;

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule